// File: doc/BRIEF.md
# Flash self-programming control register file

This block holds the two 8-bit control and status registers that a CPU uses to steer a flash controller into and out of its self-programming (rewrite) mode. It sits on a plain register bus with an address, write data, a write strobe, a read strobe and combinational read data. The block takes in the flash engine's ready/busy status, the level of the non-maskable interrupt pin and a boot-mode indication. It drives the mode controls toward the flash engine: rewrite enable, lock-bit override, flash reset, user/boot area select and power-off.

Three control bits are guarded against stray writes. Each of them can only be raised by a write of 0 followed directly by a write of 1 to the same register. Any bus access in between, whether a read or a write to another address, breaks the sequence. Idle bus cycles do not break it. Some controls take effect only while rewrite mode is on. Clearing rewrite mode drops those controls in the same cycle.

Top module: `fctl_regfile`

## Requirements
- R1: After reset, register 0 (address 0x3B6) reads 0x01 while the flash is ready and register 1 (address 0x3B7) reads 0x00. Rewrite enable, lock-bit override, flash reset and power-off are all 0.
- R2: Register 0 bit 0 returns the live ready/busy input (1 = ready, 0 = busy). Bus writes to that bit have no effect.
- R3: Register 0 bit 1 (rewrite enable) becomes 1 only when a write with bit 1 = 0 is directly followed by a write with bit 1 = 1. A lone write of 1 leaves it at 0.
- R4: A read, or a write to a different address, between the 0-write and the 1-write breaks the arming sequence, and the bit stays 0. Idle cycles with no strobe do not break it.
- R5: Register 0 bit 2 (lock-bit override) follows the same 0-then-1 rule. It is raised only if rewrite enable is already 1.
- R6: Writing 0 to a guarded bit clears it at the next clock edge, with no sequence needed.
- R7: Register 0 bit 3 (flash reset) accepts writes only while rewrite enable is 1. Otherwise it stays 0. It drives the flash reset output.
- R8: A write that clears rewrite enable also clears lock-bit override and flash reset at the same clock edge.
- R9: Register 1 bit 3 (power-off) follows the 0-then-1 rule. It is raised only if the NMI pin level is high during the 1-write.
- R10: Register 0 bit 5 is a plain read/write area bit. The user-area output equals that bit while the boot-mode input is 1 (0 = boot area, 1 = user area), and is 1 otherwise.
- R11: Register 0 bits 4, 6 and 7 and register 1 bits 0-2 and 4-7 read 0 and ignore writes. Read data is 0 when the read strobe is low or the address matches neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 10 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_rdata | output | 8 | Read data, combinational |
| flash_ready | input | 1 | Flash engine status, 1 = ready |
| nmi_level | input | 1 | NMI pin level |
| boot_mode | input | 1 | 1 when running in boot mode |
| rewrite_en | output | 1 | Rewrite mode enable |
| lockbit_off | output | 1 | Lock-bit protection disabled |
| flash_rst | output | 1 | Flash engine reset |
| user_area | output | 1 | 1 = user area, 0 = boot area |
| power_off | output | 1 | Flash power-off request |

## Verification
The assertions check several rules on every cycle. A lone 1-write never raises an unarmed bit, and a 0-write always clears a guarded bit by the next edge. Lock-bit override and flash reset never stand while rewrite mode is off. Lock-bit override rises only after rewrite mode was on, and power-off rises only after a high NMI level. Other behaviour only the bench scenarios can show: an intervening read or foreign write breaks the arming while idle cycles do not, register read-back values including the live ready bit, the boot-mode gating of the area select, and reserved bits ignoring writes.

// File: rtl/fctl_pkg.sv
package fctl_pkg;
    localparam int DATA_W   = 8;
    localparam int N_PROT   = 3;
    // guarded-bit slots
    localparam int IDX_RW   = 0;
    localparam int IDX_LOCK = 1;
    localparam int IDX_PWR  = 2;
    // bit positions in register 0
    localparam int B_RDY    = 0;
    localparam int B_RW     = 1;
    localparam int B_LOCK   = 2;
    localparam int B_FRST   = 3;
    localparam int B_AREA   = 5;
    // bit position in register 1
    localparam int B_PWR    = 3;

    typedef struct packed {
        logic primed;
        logic val;
    } arm_t;

    typedef struct packed {
        logic frst;
        logic area;
    } plain_t;
endpackage

// File: rtl/fctl_addr_dec.sv
module fctl_addr_dec #(
    parameter int          ADDR_W = 10,
    parameter logic [ADDR_W-1:0] R0_ADDR = 10'h3B6,
    parameter logic [ADDR_W-1:0] R1_ADDR = 10'h3B7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr0,
    output logic              wr1,
    output logic              rd0,
    output logic              rd1,
    output logic              any_acc
);
    logic hit0, hit1;
    always_comb begin
        hit0    = (addr == R0_ADDR);
        hit1    = (addr == R1_ADDR);
        wr0     = wr & hit0;
        wr1     = wr & hit1;
        rd0     = rd & hit0;
        rd1     = rd & hit1;
        any_acc = wr | rd;
    end
endmodule

// File: rtl/fctl_arm_bit.sv
module fctl_arm_bit
    import fctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_acc,
    input  logic hit_wr,
    input  logic wbit,
    input  logic allow,
    input  logic force_clr,
    output logic bit_q
);
    arm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // sequence state: re-armed by a 0-write, dropped by any other access
        if (hit_wr && !wbit)
            st_d.primed = 1'b1;
        else if (any_acc)
            st_d.primed = 1'b0;
        // value
        if (force_clr)
            st_d.val = 1'b0;
        else if (hit_wr && !wbit)
            st_d.val = 1'b0;
        else if (hit_wr && wbit && st_q.primed && allow)
            st_d.val = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign bit_q = st_q.val;

    // R3: an unarmed lone 1-write never raises the bit
    a_r3_lone_one: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && wbit && !st_q.primed && !st_q.val) |=> !bit_q);

    // R6: a 0-write clears the bit by the next edge
    a_r6_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wr && !wbit) |=> !bit_q);
endmodule

// File: rtl/fctl_regfile.sv
module fctl_regfile
    import fctl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter logic [ADDR_W-1:0] R0_ADDR = 10'h3B6,
    parameter logic [ADDR_W-1:0] R1_ADDR = 10'h3B7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              flash_ready,
    input  logic              nmi_level,
    input  logic              boot_mode,
    output logic              rewrite_en,
    output logic              lockbit_off,
    output logic              flash_rst,
    output logic              user_area,
    output logic              power_off
);
    logic wr0, wr1, rd0, rd1, any_acc;
    logic [N_PROT-1:0] p_hit, p_wbit, p_allow, p_force, p_q;
    plain_t pl_d, pl_q;
    logic clr_rw;
    logic [DATA_W-1:0] r0_view, r1_view;
    logic unused_wbits;

    fctl_addr_dec #(.ADDR_W(ADDR_W), .R0_ADDR(R0_ADDR), .R1_ADDR(R1_ADDR)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wr0(wr0), .wr1(wr1), .rd0(rd0), .rd1(rd1), .any_acc(any_acc)
    );

    assign clr_rw       = wr0 && !bus_wdata[B_RW];
    assign unused_wbits = ^{bus_wdata[7:6], bus_wdata[4], bus_wdata[B_RDY]};

    always_comb begin
        p_hit[IDX_RW]    = wr0;
        p_wbit[IDX_RW]   = bus_wdata[B_RW];
        p_allow[IDX_RW]  = 1'b1;
        p_force[IDX_RW]  = 1'b0;

        p_hit[IDX_LOCK]   = wr0;
        p_wbit[IDX_LOCK]  = bus_wdata[B_LOCK];
        p_allow[IDX_LOCK] = p_q[IDX_RW];
        p_force[IDX_LOCK] = clr_rw;

        p_hit[IDX_PWR]   = wr1;
        p_wbit[IDX_PWR]  = bus_wdata[B_PWR];
        p_allow[IDX_PWR] = nmi_level;
        p_force[IDX_PWR] = 1'b0;
    end

    for (genvar i = 0; i < N_PROT; i++) begin : g_prot
        fctl_arm_bit u_arm (
            .clk(clk), .rst_n(rst_n), .any_acc(any_acc),
            .hit_wr(p_hit[i]), .wbit(p_wbit[i]), .allow(p_allow[i]),
            .force_clr(p_force[i]), .bit_q(p_q[i])
        );
    end

    always_comb begin
        pl_d = pl_q;
        if (clr_rw)
            pl_d.frst = 1'b0;
        else if (wr0 && p_q[IDX_RW])
            pl_d.frst = bus_wdata[B_FRST];
        if (wr0)
            pl_d.area = bus_wdata[B_AREA];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pl_q <= '0;
        else
            pl_q <= pl_d;
    end

    always_comb begin
        r0_view         = '0;
        r0_view[B_RDY]  = flash_ready;
        r0_view[B_RW]   = p_q[IDX_RW];
        r0_view[B_LOCK] = p_q[IDX_LOCK];
        r0_view[B_FRST] = pl_q.frst;
        r0_view[B_AREA] = pl_q.area;
        r1_view         = '0;
        r1_view[B_PWR]  = p_q[IDX_PWR];
        if (rd0)
            bus_rdata = r0_view;
        else if (rd1)
            bus_rdata = r1_view;
        else
            bus_rdata = '0;
    end

    assign rewrite_en  = p_q[IDX_RW];
    assign lockbit_off = p_q[IDX_LOCK];
    assign flash_rst   = pl_q.frst;
    assign user_area   = boot_mode ? pl_q.area : 1'b1;
    assign power_off   = p_q[IDX_PWR];

    // R8: dependent controls never stand while rewrite mode is off
    a_r8_dependents_low: assert property (@(posedge clk) disable iff (!rst_n)
        !rewrite_en |-> (!lockbit_off && !flash_rst));

    // R5: lock override rises only after rewrite mode was on
    a_r5_lock_needs_rw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lockbit_off) |-> $past(rewrite_en));

    // R9: power-off rises only after a high NMI level
    a_r9_pwr_needs_nmi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(power_off) |-> $past(nmi_level));

    // R11: no read strobe gives zero read data
    a_r11_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

// File: tb/sim_fctl_regfile.sv
module sim_fctl_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       flash_ready = 1'b1;
    logic       nmi_level = 1'b0;
    logic       boot_mode = 1'b0;
    logic       rewrite_en, lockbit_off, flash_rst, user_area, power_off;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t exp_q[$];

    localparam logic [9:0] A0 = 10'h3B6;
    localparam logic [9:0] A1 = 10'h3B7;

    always #10 clk = ~clk;

    fctl_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .flash_ready(flash_ready), .nmi_level(nmi_level), .boot_mode(boot_mode),
        .rewrite_en(rewrite_en), .lockbit_off(lockbit_off), .flash_rst(flash_rst),
        .user_area(user_area), .power_off(power_off)
    );

    // monitor: compare read data during the strobe cycle
    always @(posedge clk) begin
        if (bus_rd) begin
            rd_item_t it;
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL %s unexpected read act=%02h exp=none", "scoreboard", bus_rdata);
            end else begin
                it = exp_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    failures++;
                    $display("FAIL %s read act=%02h exp=%02h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input string tag, input logic act, input logic e);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(A0, 8'h01, "R1 reg0");
        rd(A1, 8'h00, "R1 reg1");
        chk("R1 rewrite_en", rewrite_en, 1'b0);
        chk("R1 lockbit_off", lockbit_off, 1'b0);
        chk("R1 flash_rst", flash_rst, 1'b0);
        chk("R1 power_off", power_off, 1'b0);
        chk("R10 user_area outside boot", user_area, 1'b1);

        // R2 live ready bit, writes ignored
        flash_ready = 1'b0;
        rd(A0, 8'h00, "R2 busy");
        wr(A0, 8'h01);
        flash_ready = 1'b1;
        rd(A0, 8'h01, "R2 write ignored");

        // R3 lone 1 then proper arming
        wr(A0, 8'h02);
        chk("R3 lone one", rewrite_en, 1'b0);
        wr(A0, 8'h00);
        wr(A0, 8'h02);
        chk("R3 armed", rewrite_en, 1'b1);
        rd(A0, 8'h03, "R3 readback");

        // R6 immediate clear
        wr(A0, 8'h00);
        chk("R6 clear", rewrite_en, 1'b0);

        // R4 broken by read, by foreign write; idle keeps it
        wr(A0, 8'h00);
        rd(A0, 8'h01, "R4 mid read");
        wr(A0, 8'h02);
        chk("R4 read breaks", rewrite_en, 1'b0);
        wr(A0, 8'h00);
        wr(A1, 8'h00);
        wr(A0, 8'h02);
        chk("R4 foreign write breaks", rewrite_en, 1'b0);
        wr(A0, 8'h00);
        repeat (3) @(negedge clk);
        wr(A0, 8'h02);
        chk("R4 idle keeps arming", rewrite_en, 1'b1);

        // R5 lock override
        wr(A0, 8'h02);
        wr(A0, 8'h06);
        chk("R5 lock armed", lockbit_off, 1'b1);
        rd(A0, 8'h07, "R5 readback");
        wr(A0, 8'h00);
        wr(A0, 8'h04);
        chk("R5 lock without rewrite", lockbit_off, 1'b0);

        // R8 clearing rewrite drops dependents
        wr(A0, 8'h00);
        wr(A0, 8'h02);
        wr(A0, 8'h02);
        wr(A0, 8'h06);
        wr(A0, 8'h0E);
        rd(A0, 8'h0F, "R8 all set");
        wr(A0, 8'h00);
        chk("R8 rewrite off", rewrite_en, 1'b0);
        chk("R8 lock dropped", lockbit_off, 1'b0);
        chk("R8 reset dropped", flash_rst, 1'b0);

        // R7 flash reset gating
        wr(A0, 8'h08);
        chk("R7 reset ignored", flash_rst, 1'b0);
        wr(A0, 8'h00);
        wr(A0, 8'h02);
        wr(A0, 8'h0A);
        chk("R7 reset set", flash_rst, 1'b1);
        wr(A0, 8'h02);
        chk("R7 reset cleared", flash_rst, 1'b0);

        // R9 power-off with NMI gating
        nmi_level = 1'b0;
        wr(A1, 8'h00);
        wr(A1, 8'h08);
        chk("R9 nmi low", power_off, 1'b0);
        nmi_level = 1'b1;
        wr(A1, 8'h00);
        wr(A1, 8'h08);
        chk("R9 nmi high", power_off, 1'b1);
        rd(A1, 8'h08, "R9 readback");
        wr(A1, 8'h00);
        chk("R9 cleared", power_off, 1'b0);

        // R10 area select
        wr(A0, 8'h20);
        chk("R10 not boot", user_area, 1'b1);
        boot_mode = 1'b1;
        #1;
        chk("R10 boot user", user_area, 1'b1);
        wr(A0, 8'h00);
        chk("R10 boot area", user_area, 1'b0);
        rd(A0, 8'h01, "R10 readback");

        // R11 reserved bits and decode
        wr(A0, 8'hD0);
        rd(A0, 8'h01, "R11 reg0 reserved");
        wr(A1, 8'hF7);
        rd(A1, 8'h00, "R11 reg1 reserved");
        rd(10'h100, 8'h00, "R11 other addr");
        checks++;
        if (bus_rdata !== 8'h00) begin
            failures++;
            $display("FAIL R11 idle rdata act=%02h exp=00", bus_rdata);
        end

        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard pending act=%0d exp=0", exp_q.size());
        end
        finish_run();
    end
endmodule